// File: doc/BRIEF.md
# ADC Trigger Postscaler With Offset

This block turns the compare-match events of a PWM generator's time base into a stream of ADC start pulses. Each of three compare sources (A, B and C) has its own enable bit. The enabled sources are merged into one trigger event per clock cycle. That event stream then passes through two stages. The first is an offset stage, which discards a programmable number of events after each restart. The second is a postscaler, which lets one event out of every N+1 through.

The restart strobe is usually pulsed at the start of a PWM period. It reloads both stages and captures the current postscale and offset codes, which control the block until the next restart. Moving the offset shifts where the ADC sample falls within the postscale period without changing the sample rate. The output is a single-clock pulse in the same cycle as the event that qualifies.

Top module: `aptrig_top`

## Requirements
- R1: A compare pulse on `cmp_evt[i]` counts as a trigger event only when `src_en[i]` is 1. Bit 0 is source A, bit 1 is source B and bit 2 is source C. Pulses from disabled sources produce no output and do not advance either stage.
- R2: Two or three enabled compare pulses in the same clock cycle count as one trigger event.
- R3: With captured postscale code P (0 to 31), after the first output an output is produced on every (P+1)-th trigger event. Code 0 passes every event.
- R4: With captured offset code O (0 to 31), the first O trigger events after a restart produce no output. Event number O+1 produces the first output.
- R5: A cycle with `restart` high produces no output, and any compare pulse in that cycle is not counted. Counting starts fresh in the following cycle.
- R6: `trig_out` is high only in a cycle that carries a qualifying trigger event, and only for that cycle.
- R7: Changes to `ps_code` and `ofs_code` have no effect until the next `restart`.
- R8: While `rst` is high, `trig_out` is 0. After reset and before any restart, the block behaves as postscale 1:1 with zero offset, so every enabled event triggers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_evt | input | NUM_SRC | One-cycle compare-match pulses, bit 0 = A, bit 1 = B, bit 2 = C |
| src_en | input | NUM_SRC | Per-source enable for trigger counting |
| ps_code | input | PS_W | Postscale code, ratio 1:(code+1), captured at restart |
| ofs_code | input | OFS_W | Number of events to skip after restart, captured at restart |
| restart | input | 1 | Reloads both stages and captures the codes |
| trig_out | output | 1 | One-cycle ADC trigger pulse |

## Verification
The assertions assume that `cmp_evt` carries pulses that each stand for one compare match per cycle. They also assume that the codes matter only at the moment `restart` is high, because the checker keeps its own copy of the codes, taken in that cycle. The stimulus changes the code inputs freely between restarts, and it always issues a restart before a new sweep point. This keeps the checker's copy and the design's captured values aligned. It also drives disabled-source and coincident pulses, so every event the checker counts is one that the enables actually qualify.

// File: rtl/aptrig_pkg.sv
package aptrig_pkg;
  localparam int unsigned APT_SRC_N  = 3;
  localparam int unsigned APT_CODE_W = 5;

  function automatic int unsigned apt_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/aptrig_evt_merge.sv
module aptrig_evt_merge #(
  parameter int unsigned NUM_SRC = aptrig_pkg::APT_SRC_N
) (
  input  logic [NUM_SRC-1:0] cmp_evt,
  input  logic [NUM_SRC-1:0] src_en,
  output logic               evt_hit
);
  logic [NUM_SRC-1:0] qual;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_qual
      assign qual[gi] = cmp_evt[gi] & src_en[gi];
    end
  endgenerate

  assign evt_hit = |qual;
endmodule

// File: rtl/aptrig_offset.sv
module aptrig_offset #(
  parameter int unsigned W = aptrig_pkg::APT_CODE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] load_val,
  input  logic         evt,
  output logic         pass
);
  logic [W-1:0] remain;
  logic         empty;

  assign empty = (remain == '0);
  assign pass  = evt & empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain <= '0;
    end else if (restart) begin
      remain <= load_val;
    end else if (evt && !empty) begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/aptrig_postscale.sv
module aptrig_postscale #(
  parameter int unsigned W = aptrig_pkg::APT_CODE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         restart,
  input  logic [W-1:0] ratio,
  input  logic         evt,
  output logic         fire
);
  logic [W-1:0] cnt;
  logic         at_top;

  assign at_top = (cnt == ratio);
  assign fire   = evt & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (evt) begin
      cnt <= at_top ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/aptrig_top.sv
module aptrig_top #(
  parameter int unsigned NUM_SRC = aptrig_pkg::APT_SRC_N,
  parameter int unsigned PS_W    = aptrig_pkg::APT_CODE_W,
  parameter int unsigned OFS_W   = aptrig_pkg::APT_CODE_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] cmp_evt,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic [PS_W-1:0]    ps_code,
  input  logic [OFS_W-1:0]   ofs_code,
  input  logic               restart,
  output logic               trig_out
);
  logic [PS_W-1:0] ps_hold;
  logic            evt_raw;
  logic            evt_live;
  logic            after_ofs;
  logic            ps_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_hold <= '0;
    end else if (restart) begin
      ps_hold <= ps_code;
    end
  end

  aptrig_evt_merge #(.NUM_SRC(NUM_SRC)) u_merge (
    .cmp_evt (cmp_evt),
    .src_en  (src_en),
    .evt_hit (evt_raw)
  );

  assign evt_live = evt_raw & ~restart & ~rst;

  aptrig_offset #(.W(OFS_W)) u_ofs (
    .clk      (clk),
    .rst      (rst),
    .restart  (restart),
    .load_val (ofs_code),
    .evt      (evt_live),
    .pass     (after_ofs)
  );

  aptrig_postscale #(.W(PS_W)) u_ps (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .ratio   (ps_hold),
    .evt     (after_ofs),
    .fire    (ps_fire)
  );

  assign trig_out = ps_fire;
endmodule

// File: rtl/aptrig_chk.sv
module aptrig_chk #(
  parameter int unsigned NUM_SRC = aptrig_pkg::APT_SRC_N,
  parameter int unsigned PS_W    = aptrig_pkg::APT_CODE_W,
  parameter int unsigned OFS_W   = aptrig_pkg::APT_CODE_W
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] cmp_evt,
  input logic [NUM_SRC-1:0] src_en,
  input logic [PS_W-1:0]    ps_code,
  input logic [OFS_W-1:0]   ofs_code,
  input logic               restart,
  input logic               trig_out
);
  localparam int unsigned CW = aptrig_pkg::apt_max(PS_W, OFS_W) + 1;

  logic          hit;
  logic [CW-1:0] since;
  logic [CW-1:0] ps_ref;
  logic [CW-1:0] ofs_ref;
  logic          seen;

  assign hit = |(cmp_evt & src_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      since   <= '0;
      seen    <= 1'b0;
      ps_ref  <= '0;
      ofs_ref <= '0;
    end else if (restart) begin
      since   <= '0;
      seen    <= 1'b0;
      ps_ref  <= CW'(ps_code);
      ofs_ref <= CW'(ofs_code);
    end else if (hit) begin
      if (trig_out) begin
        since <= '0;
        seen  <= 1'b1;
      end else begin
        since <= since + 1'b1;
      end
    end
  end

  a_r1_needs_source: assert property (@(posedge clk) disable iff (rst)
    trig_out |-> hit);

  a_r5_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    restart |-> !trig_out);

  a_r4_first_at_offset: assert property (@(posedge clk) disable iff (rst)
    (trig_out && !seen) |-> (since == ofs_ref));

  a_r3_spacing: assert property (@(posedge clk) disable iff (rst)
    (trig_out && seen) |-> (since == ps_ref));

  a_r3_no_skip: assert property (@(posedge clk) disable iff (rst)
    (hit && !restart && seen && since == ps_ref) |-> trig_out);

  a_r4_no_skip: assert property (@(posedge clk) disable iff (rst)
    (hit && !restart && !seen && since == ofs_ref) |-> trig_out);

  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |-> !trig_out);
endmodule

bind aptrig_top aptrig_chk #(
  .NUM_SRC (NUM_SRC),
  .PS_W    (PS_W),
  .OFS_W   (OFS_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmp_evt  (cmp_evt),
  .src_en   (src_en),
  .ps_code  (ps_code),
  .ofs_code (ofs_code),
  .restart  (restart),
  .trig_out (trig_out)
);

// File: tb/sim_aptrig_top.sv
module sim_aptrig_top;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] cmp;
  logic [2:0] en;
  logic [4:0] ps;
  logic [4:0] ofs;
  logic       rs;
  logic       trig;

  int total = 0;
  int bad   = 0;
  int k     = 0;
  int cur_p = 0;
  int cur_o = 0;

  always #4 clk = ~clk;

  aptrig_top u0 (
    .clk      (clk),
    .rst      (rst),
    .cmp_evt  (cmp),
    .src_en   (en),
    .ps_code  (ps),
    .ofs_code (ofs),
    .restart  (rs),
    .trig_out (trig)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b (P=%0d O=%0d k=%0d)", tag, act, exp, cur_p, cur_o, k);
    end
  endtask

  function automatic logic want(input int kk);
    return (kk >= cur_o) && (((kk - cur_o) % (cur_p + 1)) == 0);
  endfunction

  // one cycle of compare pulses, checked mid-cycle, then dropped before the next edge
  task automatic ev(input logic [2:0] m);
    logic  h;
    string tag;
    @(negedge clk);
    cmp = m;
    #2;
    h = |(m & en);
    if (m != 0 && (m & en) == 0)       tag = "R1 disabled source";
    else if ($countones(m & en) > 1)   tag = "R2 coincident sources";
    else                               tag = "R3 R4 R6 sequence";
    chk(tag, trig, h && want(k));
    if (h) k++;
    @(posedge clk);
    #1 cmp = 3'b000;
    #1 chk("R6 single cycle", trig, 1'b0);
  endtask

  task automatic restart_to(input int p, input int o, input logic [2:0] m);
    @(negedge clk);
    ps  = 5'(p);
    ofs = 5'(o);
    rs  = 1'b1;
    cmp = m;
    #2 chk("R5 restart cycle", trig, 1'b0);
    @(negedge clk);
    rs    = 1'b0;
    cmp   = 3'b000;
    k     = 0;
    cur_p = p;
    cur_o = o;
  endtask

  function automatic logic [2:0] pat(input int i);
    case (i % 6)
      0: return 3'b001;
      1: return 3'b010;
      2: return 3'b100;
      3: return 3'b011;
      4: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  task automatic sweep_point(input int p, input int o, input logic [2:0] e);
    int n;
    en = e;
    restart_to(p, o, 3'b111);
    n = 0;
    for (int i = 0; n < o + 2 * (p + 1) + 1; i++) begin
      ev(pat(i));
      if ((pat(i) & e) != 0) n++;
    end
  endtask

  initial begin
    rst = 1'b1;
    cmp = 3'b000;
    en  = 3'b001;
    ps  = 5'd0;
    ofs = 5'd0;
    rs  = 1'b0;
    // R8: reset holds output low even with enabled pulses
    @(negedge clk);
    cmp = 3'b001;
    #2 chk("R8 reset output", trig, 1'b0);
    @(negedge clk);
    #2 chk("R8 reset output", trig, 1'b0);
    cmp = 3'b000;
    @(negedge clk);
    rst = 1'b0;
    // R8: default 1:1, zero offset before any restart; codes on pins not yet captured (R7)
    ps  = 5'd4;
    ofs = 5'd3;
    cur_p = 0; cur_o = 0; k = 0;
    for (int i = 0; i < 6; i++) ev(3'b001);

    // R7: capture P=2 O=1, then alter the pins without restart
    en = 3'b111;
    restart_to(2, 1, 3'b000);
    ps  = 5'd0;
    ofs = 5'd0;
    for (int i = 0; i < 10; i++) ev(pat(i));
    // new codes take effect at the next restart
    restart_to(0, 0, 3'b000);
    for (int i = 0; i < 4; i++) ev(3'b010);

    // near-exhaustive sweep: every postscale code at several offsets
    for (int p = 0; p < 32; p++) begin
      sweep_point(p, 0, 3'b111);
      sweep_point(p, 1, 3'b011);
      sweep_point(p, 5, 3'b101);
      sweep_point(p, 31, 3'b111);
    end
    // every offset code at two postscale codes
    for (int o = 0; o < 32; o++) begin
      sweep_point(0, o, 3'b110);
      sweep_point(3, o, 3'b111);
    end

    // R5: restart in the middle of a run, with a coincident event
    restart_to(1, 2, 3'b000);
    ev(3'b001);
    ev(3'b001);
    restart_to(1, 2, 3'b111);
    for (int i = 0; i < 8; i++) ev(3'b100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule